// File: doc/BRIEF.md
# Cascadable Up/Down Counter with Terminal-Count Pulse

This block is a wrapping binary counter built from a chain of identical four-bit stages. A single increment request adds one to the count. A single decrement request subtracts one. Each stage wraps at both ends of its range. When both requests are high together, or both are low, the count holds.

Each stage keeps a registered terminal-count flag. The flag is high for exactly one cycle after a step of that stage lands on all ones while counting up, or on zero while counting down. A hold never raises it.

The default build chains two stages into an eight-bit counter. A link between neighbouring stages steps the upper stage on exactly the edge where the lower stage wraps. A whole-counter terminal flag tells when the full value has reached its top by counting up, or zero by counting down. A data input is present on the port list, but it has no effect on the count.

Top module: `udc_cascade`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `count`, `stage_tc` and `tc` become zero at that edge, whatever `inc` and `dec` are.
- R2: With `inc`=1 and `dec`=0 at an edge, `count` becomes its previous value plus one modulo 256, so 0xFF goes to 0x00.
- R3: With `dec`=1 and `inc`=0 at an edge, `count` becomes its previous value minus one modulo 256, so 0x00 goes to 0xFF.
- R4: With `inc` and `dec` equal at an edge (both high or both low), `count` keeps its value.
- R5: `stage_tc[i]` (stage i holds `count[4i+3:4i]`) is 1 in the cycle after an edge where stage i stepped up and now reads 0xF, or stepped down and now reads 0x0. Otherwise it is 0.
- R6: Counting up, the upper nibble `count[7:4]` advances on exactly the edge where the lower nibble wraps from 0xF to 0x0, including after the lower nibble has held at 0xF for some cycles.
- R7: Counting down, the upper nibble decreases on exactly the edge where the lower nibble wraps from 0x0 to 0xF, including after holds at 0x0.
- R8: `tc` is 1 in the cycle after an increment that makes `count` 0xFF, or after a decrement that makes `count` 0x00. Otherwise it is 0, so it never stays high for two cycles.
- R9: `data_in` has no effect: changing it during holds leaves `count` unchanged.
- R10: A hold edge following a terminal landing clears `tc` and `stage_tc`, even though the count still shows the terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, wired straight to every register |
| rst_n | input | 1 | Synchronous active-low reset |
| inc | input | 1 | Increment request |
| dec | input | 1 | Decrement request |
| data_in | input | 8 | Data word present on the port list; ignored |
| count | output | 8 | Current count; stage i occupies bits [4i+3:4i] |
| stage_tc | output | 2 | Per-stage one-cycle terminal-count flags |
| tc | output | 1 | Whole-counter one-cycle terminal-count flag |

## Verification
Long unbroken runs of increments and then decrements pass through every value and both full wraparounds. These runs show that the nibble carry and borrow take effect on the wrap edge itself, with no extra clock of lag. Directed runs park the lower nibble at 0xF or 0x0 for several hold cycles before the next step. A counter that takes its carry from a stale flag would fail these runs. Holds with a changing data word, holds with both requests high, and a long stretch of random mixed requests separate real holds from stray steps. They also show that a terminal flag drops after a hold and is not set again by a count that merely sits at a terminal value.

// File: rtl/udc_pkg.sv
// Package udc_pkg
// Shared types for the cascadable up/down counter. A step code names what
// one counter stage does on the next clock edge.
package udc_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10
    } step_e;

    // Turn a pair of raw requests into a step; equal requests cancel.
    function automatic step_e decode_req(input logic up_req, input logic dn_req);
        step_e s;
        if (up_req && !dn_req) begin
            s = STEP_UP;
        end else if (dn_req && !up_req) begin
            s = STEP_DOWN;
        end else begin
            s = STEP_HOLD;
        end
        return s;
    endfunction

endpackage

// File: rtl/udc_stage.sv
// Module udc_stage
// One counter stage of W bits. It takes a step code, wraps at both ends and
// registers a terminal flag that is high for one cycle after a step lands on
// all ones (up) or zero (down). Assumes: the clock reaches the registers
// directly; the reset is synchronous and active low.
module udc_stage
    import udc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  step_e        step,
    output logic [W-1:0] count_o,
    output logic         tc_o
);

    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] count_q;
    logic         tc_q;

    // Advance the count and flag the landing on a terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            tc_q    <= 1'b0;
        end else begin
            case (step)
                STEP_UP: begin
                    count_q <= count_q + ONE;
                    tc_q    <= (count_q == (ONES - ONE));
                end
                STEP_DOWN: begin
                    count_q <= count_q - ONE;
                    tc_q    <= (count_q == ONE);
                end
                default: begin
                    count_q <= count_q;
                    tc_q    <= 1'b0;
                end
            endcase
        end
    end

    assign count_o = count_q;
    assign tc_o    = tc_q;

endmodule

// File: rtl/udc_link.sv
// Module udc_link
// Combinational carry/borrow link between two neighbouring stages. The upper
// stage steps up when the lower one steps up from all ones, and steps down
// when the lower one steps down from zero. Assumes the lower step code is
// already resolved (never both directions).
module udc_link
    import udc_pkg::*;
#(
    parameter int W = 4
) (
    input  step_e        lower_step,
    input  logic [W-1:0] lower_count,
    output step_e        upper_step
);

    localparam logic [W-1:0] ONES = {W{1'b1}};

    // Pass a step upward only when the lower stage is wrapping.
    always_comb begin
        if (lower_step == STEP_UP && lower_count == ONES) begin
            upper_step = STEP_UP;
        end else if (lower_step == STEP_DOWN && lower_count == '0) begin
            upper_step = STEP_DOWN;
        end else begin
            upper_step = STEP_HOLD;
        end
    end

endmodule

// File: rtl/udc_cascade.sv
// Module udc_cascade
// Chain of STAGES up/down counter stages, each STAGE_W bits wide, forming a
// single wrapping counter. Increment and decrement requests cancel when both
// are high. Per-stage terminal flags and a whole-counter terminal flag are
// provided. data_in is present on the port list and has no function.
// Assumes: clk drives every register directly; rst_n is synchronous.
module udc_cascade
    import udc_pkg::*;
#(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inc,
    input  logic                        dec,
    input  logic [STAGE_W*STAGES-1:0]   data_in,
    output logic [STAGE_W*STAGES-1:0]   count,
    output logic [STAGES-1:0]           stage_tc,
    output logic                        tc
);

    localparam int TOTAL_W = STAGE_W * STAGES;

    step_e step_chain [STAGES];

    // Resolve the raw requests into the lowest stage's step.
    assign step_chain[0] = decode_req(inc, dec);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        udc_stage #(.W(STAGE_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step_chain[g]),
            .count_o (count[g*STAGE_W +: STAGE_W]),
            .tc_o    (stage_tc[g])
        );
        if (g < STAGES - 1) begin : g_link
            udc_link #(.W(STAGE_W)) u_link (
                .lower_step  (step_chain[g]),
                .lower_count (count[g*STAGE_W +: STAGE_W]),
                .upper_step  (step_chain[g+1])
            );
        end
    end

    // Whole-counter flag: the lowest stage just landed and the rest agree.
    assign tc = stage_tc[0] && (count == {TOTAL_W{1'b1}} || count == '0);

endmodule

// Module udc_cascade_chk
// Assertion checker attached to udc_cascade by bind.
module udc_cascade_chk #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      inc,
    input logic                      dec,
    input logic [STAGE_W*STAGES-1:0] data_in,
    input logic [STAGE_W*STAGES-1:0] count,
    input logic [STAGES-1:0]         stage_tc,
    input logic                      tc
);

    localparam int TW = STAGE_W * STAGES;

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && stage_tc == '0 && !tc));

    a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec) |=> count == TW'($past(count) + 1'b1));

    a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |=> count == TW'($past(count) - 1'b1));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inc == dec) |=> $stable(count));

    a_r9_data_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (inc == dec && !$stable(data_in)) |=> $stable(count));

    a_r8_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);

    a_r8_tc_value: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (count == '0 || count == {TW{1'b1}}));

    a_r10_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (inc == dec) |=> (stage_tc == '0 && !tc));

endmodule

bind udc_cascade udc_cascade_chk #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (inc),
    .dec      (dec),
    .data_in  (data_in),
    .count    (count),
    .stage_tc (stage_tc),
    .tc       (tc)
);

// File: tb/udc_cascade_test.sv
// Bench for udc_cascade (two 4-bit stages). An arithmetic model tracks the
// expected count and flags; outputs are compared at every falling edge.
module udc_cascade_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inc = 1'b0;
    logic       dec = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] count;
    logic [1:0] stage_tc;
    logic       tc;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_cnt = 8'h00;
    logic [1:0] m_stc = 2'b00;
    logic       m_tc  = 1'b0;

    udc_cascade uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .dec      (dec),
        .data_in  (din),
        .count    (count),
        .stage_tc (stage_tc),
        .tc       (tc)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Apply one request pair for one edge, update the model, compare.
    task automatic step(input bit i, input bit d, input logic [7:0] dv);
        logic [7:0] old_c;
        logic [7:0] new_c;
        logic       old_tc;
        string      ctag;
        string      ttag;
        old_c  = m_cnt;
        old_tc = m_tc | (m_stc != 2'b00);
        inc = i; dec = d;
        ttag = "R8";
        if (i && !d) begin
            new_c    = old_c + 8'd1;
            m_stc[0] = (new_c[3:0] == 4'hF);
            m_stc[1] = (old_c[3:0] == 4'hF) && (new_c[7:4] == 4'hF);
            m_tc     = (new_c == 8'hFF);
            ctag     = (old_c[3:0] == 4'hF) ? "R6" : "R2";
        end else if (d && !i) begin
            new_c    = old_c - 8'd1;
            m_stc[0] = (new_c[3:0] == 4'h0);
            m_stc[1] = (old_c[3:0] == 4'h0) && (new_c[7:4] == 4'h0);
            m_tc     = (new_c == 8'h00);
            ctag     = (old_c[3:0] == 4'h0) ? "R7" : "R3";
        end else begin
            new_c = old_c;
            m_stc = 2'b00;
            m_tc  = 1'b0;
            ctag  = (dv != din) ? "R9" : "R4";
            if (old_tc) ttag = "R10";
        end
        din   = dv;
        m_cnt = new_c;
        @(posedge clk);
        @(negedge clk);
        check(ctag, "count", 32'(count), 32'(m_cnt));
        check((ttag == "R10") ? "R10" : "R5", "stage_tc", 32'(stage_tc), 32'(m_stc));
        check(ttag, "tc", 32'(tc), 32'(m_tc));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; inc = 1'b1; dec = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "count", 32'(count), 32'h0);
        check("R1", "stage_tc", 32'(stage_tc), 32'h0);
        check("R1", "tc", 32'(tc), 32'h0);
        m_cnt = 8'h00; m_stc = 2'b00; m_tc = 1'b0;
        inc = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // Long increment run: every value, full wrap, carries on wrap edges.
        for (int k = 0; k < 300; k++) step(1'b1, 1'b0, 8'h00);
        // Long decrement run: both borrow and full underflow.
        for (int k = 0; k < 300; k++) step(1'b0, 1'b1, 8'h00);
        // Holds with both requests and a changing data word.
        for (int k = 0; k < 20; k++) step(1'b1, 1'b1, 8'(k * 37));
        for (int k = 0; k < 20; k++) step(1'b0, 1'b0, 8'(k * 11 + 5));
        // Park the lower nibble at 0xF, hold, then step up and back down.
        do_reset();
        for (int k = 0; k < 15; k++) step(1'b1, 1'b0, 8'h00);
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 8'hA5);
        step(1'b1, 1'b0, 8'h00);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 8'h3C);
        step(1'b0, 1'b1, 8'h00);
        // Full terminal values followed by holds.
        for (int k = 0; k < 240; k++) step(1'b1, 1'b0, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b0, 8'h00);
        // Random mixed requests.
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom % 8);
            step(r < 3 || r == 6, (r >= 3 && r < 6) || r == 6, 8'($urandom));
        end
        // Mid-run reset with a request pending.
        do_reset();
        step(1'b0, 1'b1, 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule